// File: doc/BRIEF.md
# Selectable-Event Performance Counter Bank

This block holds four 64-bit event counters for a cache controller. Each counter carries a small configuration word. The word holds an event code, which picks what the counter accumulates, and a clear-on-read flag. Code 0 counts clock cycles. A group of codes follows single-bit event strobes, such as hits, misses and traffic. A further group follows multi-bit occupancy inputs. For those codes the counter adds the number of busy or waiting resources each cycle, so one cycle can add more than one.

Software uses a single-cycle register port to set up and read back the bank. Each counter has a configuration register and a count register. A read returns data one cycle after the request. A write to a count register loads any value, and writing zero is the explicit clear. Changing a counter's configuration never disturbs its count.

Top module: `perf_cnt_bank`

## Requirements
- R1: After reset, every count and every configuration word is zero, so every counter counts cycles. `rvalid_o` and `rdata_o` are also zero.
- R2: With event code 0 a counter adds 1 on every clock cycle.
- R3: With event code k in 1..8 a counter adds 1 in each cycle where `evt_i[k-1]` is high.
- R4: With event code k in 9..12 a counter adds the 3-bit value `occ_i[(k-9)*3 +: 3]` each cycle, a value from 0 to 7.
- R5: Codes 13..31 select no event, and the count stays unchanged.
- R6: Register address map: `addr_i[0]` selects the register kind (0 configuration, 1 count) and `addr_i[2:1]` is the counter index. A read (`req_i` high, `we_i` low) sets `rvalid_o` for exactly the next cycle. `rdata_o` then holds the value the register had before that cycle's update.
- R7: Configuration bit 8 is clear-on-read. While it is set, a read of the count returns the old value, and the counter restarts from that same cycle's increment, so no event is lost.
- R8: A configuration write leaves the count untouched. In the write cycle the counter still counts with the old code, and the new code applies from the next cycle.
- R9: A count write loads `wdata_i` in full, and that cycle's increment is dropped.
- R10: Counts wrap modulo 2^64 with no saturation.
- R11: A configuration read returns the code in bits [4:0] and clear-on-read in bit 8, with all other bits zero. Configuration write data outside those bits is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Single-bit event strobes, one per code 1..8 |
| occ_i | input | 12 | Four 3-bit occupancy counts, one per code 9..12 |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 3 | {counter index, register kind} |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
The assertions assume the following about the inputs:
- At most one access arrives per cycle, and it is either a read or a write.
- The strobe and occupancy inputs are steady around each rising edge.
- The occupancy inputs are already limited to three bits each.

The stimulus meets these assumptions as follows:
- It changes every input only at the falling edge, as a single request per step.
- It drives the strobe and occupancy inputs from a running pattern, so every code sees a mix of zero, one and multi-count cycles.
- It places reads and writes next to counting cycles, so the same-cycle read, clear and load cases occur.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  typedef enum logic {
    REG_CFG = 1'b0,
    REG_CNT = 1'b1
  } reg_kind_e;

  localparam int unsigned CFG_COR_BIT = 8;
endpackage

// File: rtl/perf_evt_sel.sv
module perf_evt_sel #(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned NUM_OCC = 4,
  parameter int unsigned OCC_W   = 3,
  parameter int unsigned SEL_W   = 5,
  localparam int unsigned TAB_N    = 2 ** SEL_W,
  localparam int unsigned NUM_CODE = 1 + NUM_EVT + NUM_OCC
) (
  input  logic [SEL_W-1:0]         code_i,
  input  logic [NUM_EVT-1:0]       evt_i,
  input  logic [NUM_OCC*OCC_W-1:0] occ_i,
  output logic [OCC_W-1:0]         inc_o
);
  logic [OCC_W-1:0] tab [TAB_N];

  for (genvar c = 0; c < TAB_N; c++) begin : g_code
    if (c == 0) begin : g_cyc
      assign tab[c] = OCC_W'(1);
    end else if (c <= NUM_EVT) begin : g_strobe
      assign tab[c] = OCC_W'(evt_i[c-1]);
    end else if (c < NUM_CODE) begin : g_occ
      assign tab[c] = occ_i[(c-1-NUM_EVT)*OCC_W +: OCC_W];
    end else begin : g_none
      assign tab[c] = '0;
    end
  end

  assign inc_o = tab[code_i];
endmodule

// File: rtl/perf_cnt_slice.sv
module perf_cnt_slice #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SEL_W = 5,
  parameter int unsigned INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_code_i,
  input  logic             cfg_cor_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cnt_rd_i,
  output logic [SEL_W-1:0] code_o,
  output logic             cor_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] inc_ext, base;
  logic             clr;

  assign inc_ext = {{(CNT_W-INC_W){1'b0}}, inc_i};
  assign clr     = cnt_rd_i & cor_o;
  assign base    = clr ? '0 : cnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      cor_o  <= 1'b0;
    end else if (cfg_we_i) begin
      code_o <= cfg_code_i;
      cor_o  <= cfg_cor_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (cnt_we_i) cnt_o <= cnt_wdata_i;
    else               cnt_o <= base + inc_ext;
  end

  // R9
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(cnt_wdata_i));

  // R7
  cor_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rd_i && cor_o && !cnt_we_i) |=> cnt_o == {{(CNT_W-INC_W){1'b0}}, $past(inc_i)});

  // R8
  cfg_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cnt_we_i && !cnt_rd_i && inc_i == '0) |=> $stable(cnt_o));

  // R10
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&cnt_o) && inc_i == INC_W'(1) && !cnt_we_i && !cnt_rd_i) |=> cnt_o == '0);
endmodule

// File: rtl/perf_reg_port.sv
module perf_reg_port
  import perf_cnt_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned SEL_W   = 5,
  localparam int unsigned IDX_W  = $clog2(NUM_CNT),
  localparam int unsigned ADDR_W = IDX_W + 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [CNT_W-1:0]                wdata_i,
  input  logic [NUM_CNT-1:0][SEL_W-1:0]   code_i,
  input  logic [NUM_CNT-1:0]              cor_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_i,
  output logic [NUM_CNT-1:0]              cfg_we_o,
  output logic [NUM_CNT-1:0]              cnt_we_o,
  output logic [NUM_CNT-1:0]              cnt_rd_o,
  output logic [SEL_W-1:0]                cfg_code_o,
  output logic                            cfg_cor_o,
  output logic [CNT_W-1:0]                rdata_o,
  output logic                            rvalid_o
);
  reg_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cfg_word, rd_mux;

  assign kind       = reg_kind_e'(addr_i[0]);
  assign idx        = addr_i[ADDR_W-1:1];
  assign cfg_code_o = wdata_i[SEL_W-1:0];
  assign cfg_cor_o  = wdata_i[CFG_COR_BIT];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
    logic hit;
    assign hit         = req_i && (idx == IDX_W'(i));
    assign cfg_we_o[i] = hit && we_i && (kind == REG_CFG);
    assign cnt_we_o[i] = hit && we_i && (kind == REG_CNT);
    assign cnt_rd_o[i] = hit && !we_i && (kind == REG_CNT);
  end

  always_comb begin
    cfg_word              = '0;
    cfg_word[SEL_W-1:0]   = code_i[idx];
    cfg_word[CFG_COR_BIT] = cor_i[idx];
    rd_mux = (kind == REG_CNT) ? cnt_i[idx] : cfg_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_mux;
    end
  end

  // R6
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  // R6
  wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  // R6
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_we_o | cnt_we_o | cnt_rd_o));
endmodule

// File: rtl/perf_cnt_bank.sv
module perf_cnt_bank #(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned NUM_OCC = 4,
  parameter int unsigned OCC_W   = 3,
  parameter int unsigned SEL_W   = 5,
  localparam int unsigned ADDR_W = $clog2(NUM_CNT) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_EVT-1:0]       evt_i,
  input  logic [NUM_OCC*OCC_W-1:0] occ_i,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CNT_W-1:0]         wdata_i,
  output logic [CNT_W-1:0]         rdata_o,
  output logic                     rvalid_o
);
  logic [NUM_CNT-1:0][SEL_W-1:0] code;
  logic [NUM_CNT-1:0]            cor;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            cfg_we, cnt_we, cnt_rd;
  logic [SEL_W-1:0]              cfg_code;
  logic                          cfg_cor;

  perf_reg_port #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_port (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .code_i(code), .cor_i(cor), .cnt_i(cnt),
    .cfg_we_o(cfg_we), .cnt_we_o(cnt_we), .cnt_rd_o(cnt_rd),
    .cfg_code_o(cfg_code), .cfg_cor_o(cfg_cor),
    .rdata_o, .rvalid_o
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [OCC_W-1:0] inc;

    perf_evt_sel #(
      .NUM_EVT(NUM_EVT), .NUM_OCC(NUM_OCC), .OCC_W(OCC_W), .SEL_W(SEL_W)
    ) u_sel (
      .code_i(code[i]), .evt_i, .occ_i, .inc_o(inc)
    );

    perf_cnt_slice #(
      .CNT_W(CNT_W), .SEL_W(SEL_W), .INC_W(OCC_W)
    ) u_slice (
      .clk_i, .rst_ni, .inc_i(inc),
      .cfg_we_i(cfg_we[i]), .cfg_code_i(cfg_code), .cfg_cor_i(cfg_cor),
      .cnt_we_i(cnt_we[i]), .cnt_wdata_i(wdata_i), .cnt_rd_i(cnt_rd[i]),
      .code_o(code[i]), .cor_o(cor[i]), .cnt_o(cnt[i])
    );

    // R3
    strobe_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code[i] >= SEL_W'(1) && code[i] <= SEL_W'(NUM_EVT)) |-> inc <= OCC_W'(1));

    // R5
    unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code[i] > SEL_W'(NUM_EVT + NUM_OCC)) |-> inc == '0);

    // R2
    cycle_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code[i] == '0) |-> inc == OCC_W'(1));
  end
endmodule

// File: tb/perf_cnt_bank_tb_top.sv
module perf_cnt_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  evt_i = '0;
  logic [11:0] occ_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic        rvalid_o;

  perf_cnt_bank dut_i (
    .clk_i(clk), .rst_ni, .evt_i, .occ_i, .req_i, .we_i, .addr_i,
    .wdata_i, .rdata_o, .rvalid_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, pc = 0;
  bit done = 1'b0;
  logic [63:0] m_cnt [4];
  logic [4:0]  m_code [4];
  logic        m_cor [4];
  logic [63:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [63:0] model_inc(logic [4:0] c, logic [7:0] e, logic [11:0] o);
    if (c == 0) return 64'd1;
    if (c <= 8) return {63'd0, e[c-1]};
    if (c <= 12) return {61'd0, o[(c-9)*3 +: 3]};
    return 64'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, starting and ending at a falling edge
  task automatic step(input logic rq, input logic w, input logic [2:0] a,
                      input logic [63:0] d, input string tag);
    logic [7:0]  e;
    logic [11:0] o;
    logic [1:0]  ix;
    e  = 8'(pc * 29 + 3);
    o  = 12'(pc * 173 + 5);
    ix = a[2:1];
    pc++;
    evt_i = e; occ_i = o; req_i = rq; we_i = w; addr_i = a; wdata_i = d;
    if (rq && !w) begin
      if (a[0]) exp_q.push_back(m_cnt[ix]);
      else      exp_q.push_back({55'd0, m_cor[ix], 3'd0, m_code[ix]});
      tag_q.push_back(tag);
    end
    for (int i = 0; i < 4; i++) begin
      logic [63:0] inc;
      inc = model_inc(m_code[i], e, o);
      if (rq && w && a[0] && ix == 2'(i)) m_cnt[i] = d;
      else if (rq && !w && a[0] && ix == 2'(i) && m_cor[i]) m_cnt[i] = inc;
      else m_cnt[i] = m_cnt[i] + inc;
    end
    if (rq && w && !a[0]) begin
      m_code[ix] = d[4:0];
      m_cor[ix]  = d[8];
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 3'd0, 64'd0, "");
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(1'b1, 1'b0, a, 64'd0, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    step(1'b1, 1'b1, a, d, "");
  endtask

  // monitor: compares each returned read against the queued expectation
  always @(negedge clk) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected rvalid", rdata_o, 64'd0);
      end else begin
        logic [63:0] ev;
        string t;
        ev = exp_q.pop_front();
        t  = tag_q.pop_front();
        check(rdata_o === ev, t, rdata_o, ev);
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_cnt[i] = '0; m_code[i] = '0; m_cor[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(rvalid_o === 1'b0, "R1 rvalid in reset", {63'd0, rvalid_o}, 64'd0);
    check(rdata_o === 64'd0, "R1 rdata in reset", rdata_o, 64'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) rd(3'(i*2), "R1");
    for (int i = 0; i < 4; i++) rd(3'(i*2+1), "R2");
    wr(3'd0, 64'h100);
    wr(3'd2, 64'd3);
    wr(3'd4, 64'd10);
    wr(3'd6, 64'd20);
    wr(3'd3, 64'd0);
    wr(3'd5, 64'd0);
    wr(3'd7, 64'd0);
    idle(25);
    rd(3'd3, "R3");
    rd(3'd5, "R4");
    rd(3'd7, "R5");
    rd(3'd1, "R7");
    rd(3'd1, "R7");
    rd(3'd0, "R11");
    rd(3'd2, "R11");
    wr(3'd2, 64'hFFFF_FFFF_FFFF_FE01);
    rd(3'd2, "R11");
    rd(3'd3, "R8");
    idle(6);
    rd(3'd3, "R7");
    wr(3'd4, 64'd0);
    wr(3'd5, 64'hFFFF_FFFF_FFFF_FFFD);
    idle(4);
    rd(3'd5, "R10");
    wr(3'd6, 64'd12);
    wr(3'd7, 64'd7);
    idle(10);
    rd(3'd7, "R4");
    rd(3'd6, "R6");
    wr(3'd1, 64'd1000);
    rd(3'd1, "R9");
    idle(3);
    check(exp_q.size() == 0, "R6 reads left unanswered", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule